// File: doc/BRIEF.md
# Multicart PRG Bank Mapper

This block sits on the cartridge side of an 8-bit console multicart and selects which 16 KB pages of a large program ROM the CPU sees in its upper 32 KB of address space. The CPU writes to two write-only configuration registers anywhere in $8000–$FFFF, with address bit 0 picking the register. From those registers and from a single toggle flip-flop the block forms a 7-bit page number and drives the upper ROM address lines for the window that the CPU is currently addressing. It also steers the nametable A10 line so that the picture memory is mirrored horizontally or vertically.

The toggle flip-flop supplies page bit 5. It is not reachable by any register write. Instead it inverts on every soft reset of the console, so a menu that reads as one set of games after power-on reads as the other half of the collection after the player presses reset. A power-on reset forces it back to zero.

Register updates are clocked; the ROM address and the nametable select are combinational functions of the registered state and the live CPU and PPU address bits.

Top module: `mc_prg_mapper`

## Requirements
- R1: A write is accepted only when `cpu_wr` is high, `rom_sel` is high and `cpu_addr[15]` is 1. `cpu_addr[0]` = 0 loads the config register and `cpu_addr[0]` = 1 loads the high-bit register.
- R2: A write with `cpu_addr[15]` = 0, or with `rom_sel` low, or with `cpu_wr` low, changes neither register; `prg_addr` and `ciram_a10` stay as before.
- R3: The page number is {high[0], toggle, config[4:0]}. Config bit 7 and high-register bits 7:1 have no effect on any output.
- R4: With config bit 5 = 0 (32 KB mode), the window at `cpu_addr[14]` = 0 maps the page with bit 0 forced to 0 and the window at `cpu_addr[14]` = 1 maps it with bit 0 forced to 1.
- R5: With config bit 5 = 1 (16 KB mode), both windows map the unmodified page.
- R6: `prg_addr` is {selected page, `cpu_addr[13:0]`}, 21 bits.
- R7: Config bit 6 = 0 (horizontal) drives `ciram_a10` from `ppu_a11`; bit 6 = 1 (vertical) drives it from `ppu_a10`.
- R8: A cycle with `soft_rst` high inverts the toggle and clears both registers on that clock edge; it takes priority over a write in the same cycle. From power-on, one soft reset gives pages 32 and 33, a second gives 0 and 1.
- R9: While `rst_n` is low, and after it rises, the toggle and both registers are zero: the lower window shows page 0 and the upper window page 1, even if the toggle was set before.
- R10: A register write takes effect on the rising clock edge that ends the write cycle and is visible on the outputs right after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Mapper clock, CPU writes sampled on the rising edge |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| soft_rst | input | 1 | Console soft reset, one clock per event, active high |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, active high |
| rom_sel | input | 1 | Cartridge ROM space select, active high |
| ppu_a10 | input | 1 | PPU address bit 10 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| prg_addr | output | 21 | Program ROM address: page and in-window offset |
| ciram_a10 | output | 1 | Nametable memory A10 select |

## Verification
The hardest state to reach is the upper half of the page space with the toggle set, because only a soft reset moves it and every soft reset also wipes both registers. The stimulus therefore issues a soft reset first and then rewrites the registers, so that 16 KB mode, the high bit and the toggle combine into pages such as 98, and afterwards drives a power-on reset while the toggle is still set to show that it returns to zero rather than inverting. A soft reset coincident with a register write is also driven to confirm the reset wins.

// File: rtl/mc_map_pkg.sv
package mc_map_pkg;

    localparam int PG_LO_W = 5;
    localparam int PAGE_W  = PG_LO_W + 2;
    localparam int REG_W   = 8;

    localparam int BIT_MODE = 5;
    localparam int BIT_MIRR = 6;

    typedef enum logic {
        MIRR_HORIZ = 1'b0,
        MIRR_VERT  = 1'b1
    } mirr_e;

    typedef enum logic {
        WIN_PAIR   = 1'b0,
        WIN_SINGLE = 1'b1
    } win_mode_e;

    typedef struct packed {
        logic [PG_LO_W-1:0] pg_lo;
        win_mode_e          mode;
        mirr_e              mirr;
        logic               pg_hi;
        logic               tog;
    } map_state_t;

endpackage

// File: rtl/mc_map_decode.sv
module mc_map_decode #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              rom_sel,
    output logic              wr_en,
    output logic              wr_hi
);
    localparam int TOP_BIT = ADDR_W - 1;

    always_comb begin
        wr_en = cpu_wr && rom_sel && cpu_addr[TOP_BIT];
        wr_hi = cpu_addr[0];
    end
endmodule

// File: rtl/mc_map_regs.sv
module mc_map_regs
    import mc_map_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    output map_state_t        st_q
);
    map_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (soft_rst) begin
            st_d     = '0;
            st_d.tog = ~st_q.tog;
        end else if (wr_en) begin
            if (wr_hi) begin
                st_d.pg_hi = wr_data[0];
            end else begin
                st_d.pg_lo = wr_data[PG_LO_W-1:0];
                st_d.mode  = win_mode_e'(wr_data[BIT_MODE]);
                st_d.mirr  = mirr_e'(wr_data[BIT_MIRR]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mc_map_window.sv
module mc_map_window
    import mc_map_pkg::*;
#(
    parameter int N_WIN = 2
) (
    input  map_state_t        st,
    input  logic              win_sel,
    output logic [PAGE_W-1:0] page,
    output logic [PAGE_W-1:0] win_page [N_WIN],
    output logic [PAGE_W-1:0] bank
);
    always_comb begin
        page = {st.pg_hi, st.tog, st.pg_lo};
    end

    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        always_comb begin
            if (st.mode == WIN_SINGLE) begin
                win_page[w] = page;
            end else begin
                win_page[w] = {page[PAGE_W-1:1], 1'(w)};
            end
        end
    end

    always_comb begin
        bank = win_page[win_sel];
    end
endmodule

// File: rtl/mc_map_mirror.sv
module mc_map_mirror
    import mc_map_pkg::*;
(
    input  mirr_e mirr,
    input  logic  ppu_a10,
    input  logic  ppu_a11,
    output logic  nt_a10
);
    always_comb begin
        unique case (mirr)
            MIRR_VERT:  nt_a10 = ppu_a10;
            default:    nt_a10 = ppu_a11;
        endcase
    end
endmodule

// File: rtl/mc_prg_mapper.sv
module mc_prg_mapper
    import mc_map_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int OFF_W  = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       soft_rst,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [DATA_W-1:0]          cpu_data,
    input  logic                       cpu_wr,
    input  logic                       rom_sel,
    input  logic                       ppu_a10,
    input  logic                       ppu_a11,
    output logic [PAGE_W+OFF_W-1:0]    prg_addr,
    output logic                       ciram_a10
);
    localparam int N_WIN = 2;

    logic              wr_en;
    logic              wr_hi;
    map_state_t        st_q;
    logic [PAGE_W-1:0] page;
    logic [PAGE_W-1:0] win_page [N_WIN];
    logic [PAGE_W-1:0] bank;

    mc_map_decode #(.ADDR_W(ADDR_W)) u_dec (
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .rom_sel  (rom_sel),
        .wr_en    (wr_en),
        .wr_hi    (wr_hi)
    );

    mc_map_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (wr_en),
        .wr_hi    (wr_hi),
        .wr_data  (cpu_data),
        .st_q     (st_q)
    );

    mc_map_window #(.N_WIN(N_WIN)) u_win (
        .st       (st_q),
        .win_sel  (cpu_addr[OFF_W]),
        .page     (page),
        .win_page (win_page),
        .bank     (bank)
    );

    mc_map_mirror u_mirr (
        .mirr     (st_q.mirr),
        .ppu_a10  (ppu_a10),
        .ppu_a11  (ppu_a11),
        .nt_a10   (ciram_a10)
    );

    always_comb begin
        prg_addr = {bank, cpu_addr[OFF_W-1:0]};
    end
endmodule

// File: rtl/mc_prg_mapper_chk.sv
module mc_prg_mapper_chk
    import mc_map_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 14
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    soft_rst,
    input logic [ADDR_W-1:0]       cpu_addr,
    input logic                    cpu_wr,
    input logic                    rom_sel,
    input logic                    ppu_a10,
    input logic                    ppu_a11,
    input logic [PAGE_W+OFF_W-1:0] prg_addr,
    input logic                    ciram_a10,
    input map_state_t              st_q,
    input logic [PAGE_W-1:0]       page,
    input logic [PAGE_W-1:0]       win_page [2]
);
    localparam int TOG_BIT = OFF_W + PG_LO_W;

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_PWR_CLEAR: assert (prg_addr[PAGE_W+OFF_W-1:OFF_W+1] == '0 && prg_addr[OFF_W] == cpu_addr[OFF_W]); // R9
        end
    end

    AST_SOFT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (prg_addr[TOG_BIT] != $past(prg_addr[TOG_BIT])) && st_q.pg_lo == '0 && !st_q.pg_hi); // R8

    AST_WIN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == WIN_PAIR) |-> (prg_addr[OFF_W] == cpu_addr[OFF_W])); // R4

    AST_WIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == WIN_SINGLE) |-> (win_page[0] == page && win_page[1] == page)); // R5

    AST_LOW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && (!cpu_wr || !rom_sel || !cpu_addr[ADDR_W-1])) |=> $stable(st_q)); // R2

    AST_MIRR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        ciram_a10 == ((st_q.mirr == MIRR_VERT) ? ppu_a10 : ppu_a11)); // R7

    AST_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        prg_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]); // R6
endmodule

bind mc_prg_mapper mc_prg_mapper_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .rom_sel   (rom_sel),
    .ppu_a10   (ppu_a10),
    .ppu_a11   (ppu_a11),
    .prg_addr  (prg_addr),
    .ciram_a10 (ciram_a10),
    .st_q      (st_q),
    .page      (page),
    .win_page  (win_page)
);

// File: tb/sim_mc_prg_mapper.sv
`timescale 1ns/1ps
module sim_mc_prg_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr = 1'b0;
    logic        rom_sel = 1'b0;
    logic        ppu_a10 = 1'b0;
    logic        ppu_a11 = 1'b0;
    logic [20:0] prg_addr;
    logic        ciram_a10;

    int checks = 0;
    int errors = 0;
    int pat = 0;
    bit done = 0;

    // reference state
    int m_cfg = 0;
    int m_hi  = 0;
    int m_tog = 0;

    always #2 clk = ~clk;

    mc_prg_mapper u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .cpu_wr(cpu_wr), .rom_sel(rom_sel),
        .ppu_a10(ppu_a10), .ppu_a11(ppu_a11), .prg_addr(prg_addr), .ciram_a10(ciram_a10)
    );

    function automatic int exp_page();
        int p;
        int pg;
        pg = (m_cfg & 31) + 32 * m_tog + 64 * (m_hi & 1);
        if ((m_cfg & 32) != 0) p = pg;
        else p = (pg & 126) + (cpu_addr[14] ? 1 : 0);
        return p;
    endfunction

    task automatic compare(input string tag);
        logic [20:0] ea;
        logic        em;
        ea = {7'(exp_page()), cpu_addr[13:0]};
        em = ((m_cfg & 64) != 0) ? ppu_a10 : ppu_a11;
        checks++;
        if (prg_addr !== ea) begin
            errors++;
            $display("FAIL %s prg_addr actual=%0d expected=%0d (page act %0d exp %0d)",
                     tag, prg_addr, ea, prg_addr[20:14], ea[20:14]);
        end
        checks++;
        if (ciram_a10 !== em) begin
            errors++;
            $display("FAIL %s ciram_a10 actual=%0b expected=%0b", tag, ciram_a10, em);
        end
    endtask

    task automatic look(input string tag);
        cpu_addr[14] = 1'b0;
        cpu_addr[13:0] = 14'(pat * 977);
        ppu_a10 = pat[0];
        ppu_a11 = pat[1];
        #0.2;
        compare(tag);
        cpu_addr[14] = 1'b1;
        ppu_a10 = ~pat[0];
        #0.2;
        compare(tag);
        pat++;
    endtask

    task automatic step(input logic wr, input logic [15:0] a, input logic [7:0] d,
                        input logic rs, input logic sr, input string tag);
        cpu_wr = wr; cpu_addr = a; cpu_data = d; rom_sel = rs; soft_rst = sr;
        @(posedge clk);
        if (sr) begin
            m_tog = 1 - m_tog; m_cfg = 0; m_hi = 0;
        end else if (wr && rs && a[15]) begin
            if (a[0]) m_hi = d; else m_cfg = d;
        end
        #1;
        cpu_wr = 1'b0; soft_rst = 1'b0; rom_sel = 1'b0;
        look(tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9 during and after power-on reset
        repeat (2) @(posedge clk);
        #1; look("R9");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1; look("R9");

        // R1 R4 R10: page 4 pair, odd page aligns
        step(1, 16'h8000, 8'h04, 1, 0, "R10");
        step(1, 16'hE002, 8'h05, 1, 0, "R4");
        // R5 single window
        step(1, 16'h8000, 8'h23, 1, 0, "R5");
        // R1 high bit and R3 composition
        step(1, 16'h8000, 8'h22, 1, 0, "R1");
        step(1, 16'hFFFF, 8'h01, 1, 0, "R3");
        // R3 ignored bits
        step(1, 16'h8000, 8'hA2, 1, 0, "R3");
        step(1, 16'h9001, 8'hFF, 1, 0, "R3");
        step(1, 16'h9001, 8'hFE, 1, 0, "R3");
        // R2 ignored writes
        step(1, 16'h6000, 8'h5F, 1, 0, "R2");
        step(1, 16'h7FFF, 8'h01, 1, 0, "R2");
        step(1, 16'hC000, 8'h7F, 0, 0, "R2");
        step(0, 16'hC000, 8'h7F, 1, 0, "R2");
        // R7 mirroring both ways
        step(1, 16'h8000, 8'h40, 1, 0, "R7");
        for (int i = 0; i < 4; i++) step(0, 16'h0000, 8'h00, 0, 0, "R7");
        step(1, 16'h8000, 8'h00, 1, 0, "R7");
        for (int i = 0; i < 4; i++) step(0, 16'h0000, 8'h00, 0, 0, "R7");
        // R6 offsets
        for (int i = 0; i < 8; i++) step(1, 16'h8000, 8'(i * 37), 1, 0, "R6");
        // R8 soft reset sequence
        step(1, 16'h8000, 8'h04, 1, 0, "R8");
        step(0, 16'h0000, 8'h00, 0, 1, "R8");
        step(0, 16'h0000, 8'h00, 0, 1, "R8");
        step(0, 16'h0000, 8'h00, 0, 1, "R8");
        // toggle set: reach upper pages
        step(1, 16'h8000, 8'h22, 1, 0, "R3");
        step(1, 16'h8001, 8'h01, 1, 0, "R3");
        // soft reset wins over a simultaneous write
        step(1, 16'h8000, 8'h7F, 1, 1, "R8");
        step(1, 16'h8001, 8'h01, 1, 0, "R1");
        step(1, 16'h8000, 8'h7F, 1, 0, "R1");
        // power-on reset with toggle clear... then set, then reset
        step(0, 16'h0000, 8'h00, 0, 1, "R8");
        #0.5; rst_n = 1'b0; m_tog = 0; m_cfg = 0; m_hi = 0;
        #0.5; look("R9");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1; look("R9");
        step(0, 16'h0000, 8'h00, 0, 1, "R8");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule